// File: doc/BRIEF.md
# Shared Descriptor Ring Overrun Controller

This block governs one circular ring of buffer descriptors that two agents use in common. A producer (the cell-receive side) fills entries one at a time, and a consumer (the TDM-transmit side) drains them in the same circular order. The controller keeps a valid bit for every entry, one index for each agent, and an occupancy counter. The agents present a request for each entry. The controller answers in the same cycle with an acknowledge and the index of the entry involved. Payload storage lives elsewhere.

Four programmable thresholds govern the two agents. The consumer starts draining once occupancy climbs to its start level, and it pauses once occupancy falls to its stop level. The producer stops filling when occupancy reaches its stop level, which is normally the ring size minus one. The producer stays frozen until occupancy falls back to its restart level. At that point it does not resume where it stopped. It jumps to the entry that follows the most recent end-of-superframe marker. The entries of the partial superframe are discarded, so that the next fill starts a fresh superframe and sync is recovered. A sticky overrun flag records each freeze until it is cleared by a write-one pulse.

Top module: `ring_overrun_ctrl`

## Requirements
- R1: After synchronous reset, occupancy is 0, both indices are 0, every entry is empty, the producer is not frozen, the consumer is idle, the overrun flag is 0, and the end-of-superframe record points at entry DEPTH-1.
- R2: A fill is acknowledged in the same cycle when all of these hold: fill_req is high, the producer is not frozen, occupancy is below the producer stop threshold, and the entry at fill_idx is empty. An acknowledged fill marks that entry valid and advances fill_idx by one, from DEPTH-1 back to 0. If fill_eosf is high, it also records that entry as the latest end-of-superframe.
- R3: A drain is acknowledged in the same cycle when drain_req is high, the consumer is running, and the entry at drain_idx is valid. It empties that entry and advances drain_idx by one, from DEPTH-1 back to 0.
- R4: Occupancy rises by one for a lone fill and falls by one for a lone drain. It is unchanged when both happen in one cycle, and it never leaves the range 0 to DEPTH.
- R5: An idle consumer starts running in the cycle after occupancy is at or above the consumer start threshold. A running consumer goes idle in the cycle after occupancy is at or below the consumer stop threshold.
- R6: A producer that is not frozen becomes frozen in the cycle after occupancy is at or above the producer stop threshold. While frozen, fill requests are refused and leave occupancy and fill_idx unchanged.
- R7: While the producer is frozen, drains continue to be acknowledged and to lower occupancy.
- R8: A frozen producer whose occupancy is at or below the producer restart threshold raises resync for that cycle and is not frozen in the next cycle. In that next cycle, fill_idx equals the entry after the recorded end-of-superframe entry. The entries from that target up to, but not including, the frozen fill_idx are emptied, and occupancy equals the number of entries still valid. If drain_idx lay within that span, including the frozen fill_idx itself, it is moved to the target.
- R9: The overrun flag goes high in the cycle after a freeze begins. It then stays high until an ovr_clr pulse arrives in a cycle that starts no new freeze. A new freeze wins over a simultaneous clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_cons_start | input | CNT_W | Occupancy at which the consumer starts |
| thr_cons_stop | input | CNT_W | Occupancy at which the consumer pauses |
| thr_prod_stop | input | CNT_W | Occupancy at which the producer freezes |
| thr_prod_start | input | CNT_W | Occupancy at which a frozen producer resynchronises |
| ovr_clr | input | 1 | Write-one-to-clear pulse for the overrun flag |
| fill_req | input | 1 | Producer offers one entry |
| fill_eosf | input | 1 | The offered entry ends a superframe |
| fill_ack | output | 1 | Fill accepted this cycle |
| fill_idx | output | IDX_W | Entry the producer writes next |
| drain_req | input | 1 | Consumer asks for one entry |
| drain_ack | output | 1 | Drain accepted this cycle |
| drain_idx | output | IDX_W | Entry the consumer reads next |
| occupancy | output | CNT_W | Number of filled entries |
| cons_running | output | 1 | Consumer is allowed to drain |
| prod_frozen | output | 1 | Producer is frozen |
| resync | output | 1 | Producer jumps to the superframe boundary this cycle |
| ovr_sticky | output | 1 | Overrun flag |

## Verification
Several properties are checked on every cycle: a frozen producer never receives a fill acknowledge, a drain is never acknowledged without the run permission, a lone fill steps occupancy up by exactly one, and a paired fill and drain leave it unchanged. The checks also confirm that reaching the stop thresholds flips the freeze and run states one cycle later, and that every freeze raises the overrun flag. Other behaviour can only be shown by the bench's scenarios. This covers where the producer lands after a resync, which entries of the partial superframe are discarded, the occupancy that results, and the relocation of the drain index. The bench compares all of these against a reference model across a directed overrun-and-recovery sequence and biased random traffic under two threshold sets.

// File: rtl/ring_ovr_pkg.sv
package ring_ovr_pkg;

    typedef enum logic {
        PROD_FILL   = 1'b0,
        PROD_FROZEN = 1'b1
    } prod_mode_e;

    typedef enum logic {
        CONS_IDLE = 1'b0,
        CONS_RUN  = 1'b1
    } cons_mode_e;

    // One step forward around a ring of the given depth.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx + 1 >= depth) ? 0 : idx + 1;
    endfunction

    // Number of forward steps from 'from' to 'to'.
    function automatic int unsigned ring_dist(int unsigned from, int unsigned to,
                                              int unsigned depth);
        return (to >= from) ? (to - from) : (to + depth - from);
    endfunction

    // Saturating occupancy update.
    function automatic int unsigned occ_step(int unsigned occ, logic up, logic dn,
                                             int unsigned depth);
        if (up && !dn) return (occ >= depth) ? depth : occ + 1;
        if (dn && !up) return (occ == 0) ? 0 : occ - 1;
        return occ;
    endfunction

endpackage

// File: rtl/orc_prod_gate.sv
module orc_prod_gate
    import ring_ovr_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] thr_stop,
    input  logic [CNT_W-1:0] thr_start,
    input  logic             ovr_clr,
    output logic             fill_allow,
    output logic             resume,
    output logic             frozen,
    output logic             sticky
);
    prod_mode_e mode;
    logic       freeze_evt;

    always_comb begin
        frozen     = (mode == PROD_FROZEN);
        fill_allow = (mode == PROD_FILL) && (occ < thr_stop);
        freeze_evt = (mode == PROD_FILL) && (occ >= thr_stop);
        resume     = (mode == PROD_FROZEN) && (occ <= thr_start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= PROD_FILL;
            sticky <= 1'b0;
        end else begin
            if (freeze_evt)  mode <= PROD_FROZEN;
            else if (resume) mode <= PROD_FILL;
            if (freeze_evt)   sticky <= 1'b1;
            else if (ovr_clr) sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/orc_cons_gate.sv
module orc_cons_gate
    import ring_ovr_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] thr_start,
    input  logic [CNT_W-1:0] thr_stop,
    output logic             running
);
    cons_mode_e mode;

    assign running = (mode == CONS_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= CONS_IDLE;
        end else begin
            case (mode)
                CONS_IDLE: if (occ >= thr_start) mode <= CONS_RUN;
                CONS_RUN:  if (occ <= thr_stop)  mode <= CONS_IDLE;
                default:   mode <= CONS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/orc_ring_state.sv
module orc_ring_state
    import ring_ovr_pkg::*;
#(
    parameter int unsigned DEPTH = 7,
    parameter int unsigned IDX_W = 3,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_req,
    input  logic             fill_eosf,
    input  logic             fill_allow,
    input  logic             drain_req,
    input  logic             cons_running,
    input  logic             resume,
    output logic             fill_ack,
    output logic             drain_ack,
    output logic [IDX_W-1:0] prod_ptr,
    output logic [IDX_W-1:0] cons_ptr,
    output logic [CNT_W-1:0] occ
);
    logic [DEPTH-1:0] valid_q, valid_n;
    logic [IDX_W-1:0] eosf_q, eosf_n;
    logic [IDX_W-1:0] prod_n, cons_n;
    logic [CNT_W-1:0] occ_n;
    int unsigned      tgt;
    int unsigned      npart;
    int unsigned      live;

    assign fill_ack  = fill_req && fill_allow && !valid_q[prod_ptr];
    assign drain_ack = drain_req && cons_running && valid_q[cons_ptr];

    always_comb begin
        valid_n = valid_q;
        prod_n  = prod_ptr;
        cons_n  = cons_ptr;
        eosf_n  = eosf_q;
        tgt     = 0;
        npart   = 0;
        live    = 0;
        if (fill_ack) begin
            valid_n[prod_ptr] = 1'b1;
            prod_n = IDX_W'(ring_next(int'(prod_ptr), DEPTH));
            if (fill_eosf) eosf_n = prod_ptr;
        end
        if (drain_ack) begin
            valid_n[cons_ptr] = 1'b0;
            cons_n = IDX_W'(ring_next(int'(cons_ptr), DEPTH));
        end
        occ_n = CNT_W'(occ_step(int'(occ), fill_ack, drain_ack, DEPTH));
        if (resume) begin
            // Discard the partial superframe and rewind to its first entry.
            tgt   = ring_next(int'(eosf_q), DEPTH);
            npart = ring_dist(tgt, int'(prod_ptr), DEPTH);
            for (int i = 0; i < DEPTH; i++) begin
                if (ring_dist(tgt, i, DEPTH) < npart) valid_n[i] = 1'b0;
            end
            if (ring_dist(tgt, int'(cons_n), DEPTH) <= npart) cons_n = IDX_W'(tgt);
            prod_n = IDX_W'(tgt);
            for (int i = 0; i < DEPTH; i++) begin
                if (valid_n[i]) live = live + 1;
            end
            occ_n = CNT_W'(live);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            prod_ptr <= '0;
            cons_ptr <= '0;
            eosf_q   <= IDX_W'(DEPTH - 1);
            occ      <= '0;
        end else begin
            valid_q  <= valid_n;
            prod_ptr <= prod_n;
            cons_ptr <= cons_n;
            eosf_q   <= eosf_n;
            occ      <= occ_n;
        end
    end
endmodule

// File: rtl/ring_overrun_ctrl.sv
module ring_overrun_ctrl
    import ring_ovr_pkg::*;
#(
    parameter int unsigned DEPTH = 7,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] thr_cons_start,
    input  logic [CNT_W-1:0] thr_cons_stop,
    input  logic [CNT_W-1:0] thr_prod_stop,
    input  logic [CNT_W-1:0] thr_prod_start,
    input  logic             ovr_clr,
    input  logic             fill_req,
    input  logic             fill_eosf,
    output logic             fill_ack,
    output logic [IDX_W-1:0] fill_idx,
    input  logic             drain_req,
    output logic             drain_ack,
    output logic [IDX_W-1:0] drain_idx,
    output logic [CNT_W-1:0] occupancy,
    output logic             cons_running,
    output logic             prod_frozen,
    output logic             resync,
    output logic             ovr_sticky
);
    logic fill_allow;

    orc_prod_gate #(.CNT_W(CNT_W)) i_prod_gate (
        .clk        (clk),
        .rst        (rst),
        .occ        (occupancy),
        .thr_stop   (thr_prod_stop),
        .thr_start  (thr_prod_start),
        .ovr_clr    (ovr_clr),
        .fill_allow (fill_allow),
        .resume     (resync),
        .frozen     (prod_frozen),
        .sticky     (ovr_sticky)
    );

    orc_cons_gate #(.CNT_W(CNT_W)) i_cons_gate (
        .clk       (clk),
        .rst       (rst),
        .occ       (occupancy),
        .thr_start (thr_cons_start),
        .thr_stop  (thr_cons_stop),
        .running   (cons_running)
    );

    orc_ring_state #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_ring_state (
        .clk          (clk),
        .rst          (rst),
        .fill_req     (fill_req),
        .fill_eosf    (fill_eosf),
        .fill_allow   (fill_allow),
        .drain_req    (drain_req),
        .cons_running (cons_running),
        .resume       (resync),
        .fill_ack     (fill_ack),
        .drain_ack    (drain_ack),
        .prod_ptr     (fill_idx),
        .cons_ptr     (drain_idx),
        .occ          (occupancy)
    );
endmodule

// File: rtl/orc_checker.sv
module orc_checker #(
    parameter int unsigned DEPTH = 7,
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] thr_cons_stop,
    input logic [CNT_W-1:0] thr_prod_stop,
    input logic             fill_ack,
    input logic             drain_ack,
    input logic [CNT_W-1:0] occupancy,
    input logic             cons_running,
    input logic             prod_frozen,
    input logic             resync,
    input logic             ovr_sticky
);
    AST_OCC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CNT_W'(DEPTH)); // R4

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
        fill_ack && !drain_ack |=> occupancy == $past(occupancy) + 1'b1); // R4

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        fill_ack && drain_ack && !resync |=> $stable(occupancy)); // R4

    AST_DRAIN_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        drain_ack |-> cons_running); // R3

    AST_CONS_PAUSE: assert property (@(posedge clk) disable iff (rst)
        cons_running && occupancy <= thr_cons_stop |=> !cons_running); // R5

    AST_FREEZE_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        !prod_frozen && occupancy >= thr_prod_stop |=> prod_frozen); // R6

    AST_NO_FILL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        prod_frozen |-> !fill_ack); // R6

    AST_RESYNC_THAWS: assert property (@(posedge clk) disable iff (rst)
        resync |=> !prod_frozen); // R8

    AST_FREEZE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        $rose(prod_frozen) |-> ovr_sticky); // R9
endmodule

bind ring_overrun_ctrl orc_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_orc_checker (
    .clk           (clk),
    .rst           (rst),
    .thr_cons_stop (thr_cons_stop),
    .thr_prod_stop (thr_prod_stop),
    .fill_ack      (fill_ack),
    .drain_ack     (drain_ack),
    .occupancy     (occupancy),
    .cons_running  (cons_running),
    .prod_frozen   (prod_frozen),
    .resync        (resync),
    .ovr_sticky    (ovr_sticky)
);

// File: tb/test_ring_overrun_ctrl.sv
module test_ring_overrun_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int D = 7;
    localparam int IW = 3;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] thr_cons_start, thr_cons_stop, thr_prod_stop, thr_prod_start;
    logic          ovr_clr, fill_req, fill_eosf, drain_req;
    logic          fill_ack, drain_ack, cons_running, prod_frozen, resync, ovr_sticky;
    logic [IW-1:0] fill_idx, drain_idx;
    logic [CW-1:0] occupancy;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    logic [D-1:0] m_valid;
    int m_prod, m_cons, m_cnt, m_eosf;
    bit m_frz, m_run, m_stk;

    ring_overrun_ctrl #(.DEPTH(D)) i_ring_overrun_ctrl (
        .clk(clk), .rst(rst),
        .thr_cons_start(thr_cons_start), .thr_cons_stop(thr_cons_stop),
        .thr_prod_stop(thr_prod_stop), .thr_prod_start(thr_prod_start),
        .ovr_clr(ovr_clr), .fill_req(fill_req), .fill_eosf(fill_eosf),
        .fill_ack(fill_ack), .fill_idx(fill_idx),
        .drain_req(drain_req), .drain_ack(drain_ack), .drain_idx(drain_idx),
        .occupancy(occupancy), .cons_running(cons_running),
        .prod_frozen(prod_frozen), .resync(resync), .ovr_sticky(ovr_sticky)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [D-1:0] v);
        int n = 0;
        for (int k = 0; k < D; k++) n += int'(v[k]);
        return n;
    endfunction

    task automatic model_reset();
        m_valid = '0; m_prod = 0; m_cons = 0; m_cnt = 0; m_eosf = D - 1;
        m_frz = 0; m_run = 0; m_stk = 0;
    endtask

    task automatic check_regs();
        chk(int'(occupancy) == m_cnt, "R4 occupancy", int'(occupancy), m_cnt);
        chk(int'(fill_idx) == m_prod, "R2 fill_idx", int'(fill_idx), m_prod);
        chk(int'(drain_idx) == m_cons, "R3 drain_idx", int'(drain_idx), m_cons);
        chk(cons_running == m_run, "R5 cons_running", int'(cons_running), int'(m_run));
        chk(prod_frozen == m_frz, "R6 prod_frozen", int'(prod_frozen), int'(m_frz));
        chk(ovr_sticky == m_stk, "R9 ovr_sticky", int'(ovr_sticky), int'(m_stk));
    endtask

    // Called just after a falling edge; returns after the next falling edge.
    task automatic tick(input bit f, input bit e, input bit d, input bit clr);
        bit x_fill, x_drain, x_rs, fev;
        logic [D-1:0] n_valid;
        int n_prod, n_cons, n_cnt, n_eosf, tgt, npart;
        fill_req = f; fill_eosf = e; drain_req = d; ovr_clr = clr;
        #(CLK_PERIOD/2 - 1);
        x_fill  = f && !m_frz && (m_cnt < int'(thr_prod_stop)) && !m_valid[m_prod];
        x_drain = d && m_run && m_valid[m_cons];
        x_rs    = m_frz && (m_cnt <= int'(thr_prod_start));
        chk(fill_ack == x_fill, "R2 fill_ack", int'(fill_ack), int'(x_fill));
        chk(drain_ack == x_drain, "R3 drain_ack", int'(drain_ack), int'(x_drain));
        chk(resync == x_rs, "R8 resync", int'(resync), int'(x_rs));
        n_valid = m_valid; n_prod = m_prod; n_cons = m_cons; n_eosf = m_eosf;
        n_cnt = m_cnt + int'(x_fill) - int'(x_drain);
        if (x_fill) begin
            n_valid[m_prod] = 1'b1;
            if (e) n_eosf = m_prod;
            n_prod = (m_prod + 1) % D;
        end
        if (x_drain) begin
            n_valid[m_cons] = 1'b0;
            n_cons = (m_cons + 1) % D;
        end
        if (x_rs) begin
            tgt = (m_eosf + 1) % D;
            npart = (m_prod - tgt + D) % D;
            for (int k = 0; k < npart; k++) n_valid[(tgt + k) % D] = 1'b0;
            if ((n_cons - tgt + D) % D <= npart) n_cons = tgt;
            n_prod = tgt;
            n_cnt = popc(n_valid);
        end
        fev = !m_frz && (m_cnt >= int'(thr_prod_stop));
        @(posedge clk);
        m_stk = fev ? 1'b1 : (clr ? 1'b0 : m_stk);
        m_frz = m_frz ? !(m_cnt <= int'(thr_prod_start)) : fev;
        m_run = m_run ? !(m_cnt <= int'(thr_cons_stop)) : (m_cnt >= int'(thr_cons_start));
        m_valid = n_valid; m_prod = n_prod; m_cons = n_cons; m_cnt = n_cnt; m_eosf = n_eosf;
        #1;
        check_regs();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; fill_req = 0; fill_eosf = 0; drain_req = 0; ovr_clr = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: reset state
        chk(occupancy == '0 && fill_idx == '0 && drain_idx == '0, "R1 counters", int'(occupancy), 0);
        chk(!prod_frozen && !cons_running && !ovr_sticky, "R1 flags",
            int'({prod_frozen, cons_running, ovr_sticky}), 0);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        bit bias;
        void'($urandom(32'd1357));
        thr_cons_start = 3'd3; thr_cons_stop = 3'd1;
        thr_prod_stop = 3'd6; thr_prod_start = 3'd5;
        do_reset();

        // Directed overrun and recovery; end-of-superframe on entry 3.
        for (int k = 0; k < 6; k++) tick(1, k == 3, 0, 0);
        tick(1, 0, 0, 0);                    // freeze registers now
        chk(prod_frozen == 1'b1, "R6 frozen at stop", int'(prod_frozen), 1);
        chk(int'(fill_idx) == 6, "R6 fill_idx held", int'(fill_idx), 6);
        chk(ovr_sticky == 1'b1, "R9 flag on freeze", int'(ovr_sticky), 1);
        tick(1, 0, 0, 0);
        chk(int'(occupancy) == 6, "R6 refused fill ignored", int'(occupancy), 6);
        tick(0, 0, 1, 0);                    // R7: drain while frozen
        chk(int'(occupancy) == 5, "R7 drain while frozen", int'(occupancy), 5);
        tick(0, 0, 0, 0);                    // resync cycle
        chk(prod_frozen == 1'b0, "R8 thawed", int'(prod_frozen), 0);
        chk(int'(fill_idx) == 4, "R8 target after eosf", int'(fill_idx), 4);
        chk(int'(occupancy) == 3, "R8 partial discarded", int'(occupancy), 3);
        tick(0, 0, 0, 1);
        chk(ovr_sticky == 1'b0, "R9 cleared", int'(ovr_sticky), 0);
        tick(1, 0, 1, 0);                    // simultaneous fill and drain
        chk(int'(occupancy) == 3, "R4 pair holds", int'(occupancy), 3);

        // Biased random traffic, two threshold sets.
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin
                thr_cons_start = 3'd2; thr_cons_stop = 3'd0;
                thr_prod_stop = 3'd4; thr_prod_start = 3'd2;
                do_reset();
            end
            for (int n = 0; n < 4000; n++) begin
                bias = ((n / 150) % 2) == 0;
                tick(($urandom % 100) < (bias ? 85 : 35),
                     ($urandom % 4) == 0,
                     ($urandom % 100) < (bias ? 30 : 80),
                     ($urandom % 40) == 0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule